// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a per-core countdown timer. Software programs three things: a timer entry that holds an interrupt vector, a mask bit and a mode field; an initial count; and a divide setting that picks how many clock cycles make up one count step. Writing a nonzero initial count starts the countdown. When the count goes from one to zero, the timer has expired. In one-shot mode it then stops at zero. In periodic mode it reloads the initial count and keeps running. An unmasked expiry raises an interrupt request that carries the programmed vector.

Register writes use a single plain write port. `wr_sel` picks the target: 0 is the timer entry, 1 is the initial count, 2 is the divide setting, and 3 selects nothing. All register contents are visible at all times on plain output ports.

The interrupt request leaves the block through a valid/ready pair. Once `irq_valid` is high, it and `irq_vec` hold steady until `irq_ready` is sampled high at a clock edge. While a request waits unaccepted, further expiries merge into it and do not replace its vector. The `sw_enable` input is a level. While it is low, the entry's mask bit is held set.

Top module: `loc_timer`

## Requirements
- R1: After reset, the entry reads 0x0001_0000 (masked, one-shot, vector 0), both counts read 0, the divide setting reads 0 and `irq_valid` is low.
- R2: A divide write keeps only data bits 3, 1 and 0, and all other bits read zero. The code is {bit3, bit1, bit0}, and the divisor is 2 to the power ((code+1) mod 8). So code 7 divides by 1, code 0 by 2 and code 6 by 128.
- R3: While the current count is nonzero, it drops by one every divisor cycles. The first drop happens divisor clock edges after the edge that loaded it, and the count holds steady between steps.
- R4: In mode 00 or 01, a nonzero initial-count write loads both the initial and current counts. A zero write stops the timer and clears both counts.
- R5: In one-shot mode (mode 00), the step from 1 leaves the current count at 0, and it stays there.
- R6: In periodic mode (mode 01), the step from 1 reloads the current count from the initial count, so the current count never exceeds the initial count.
- R7: An entry write whose mode field (bits 18:17) differs from the stored mode stops the timer and clears both counts.
- R8: In modes 10 and 11, initial-count writes are ignored and both count outputs read zero.
- R9: The entry keeps the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17. Every other entry bit reads zero.
- R10: While `sw_enable` is low, the stored mask bit is set one edge later, and any entry write stores the mask as 1.
- R11: An expiry raises `irq_valid` on the same edge, with `irq_vec` equal to entry bits 7:0 as they stood before that edge. No request is raised if the mask bit is set or `sw_enable` is low.
- R12: `irq_valid` and `irq_vec` hold until a clock edge samples `irq_ready` high. The request then drops unless a new unmasked expiry happens at that same edge, in which case it stays valid with the new vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; counting is measured in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Software enable; low forces the entry masked |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 entry, 1 initial count, 2 divide, 3 none |
| wr_data | input | 32 | Write data |
| entry_o | output | 32 | Timer entry (vector 7:0, mask 16, mode 18:17) |
| init_cnt_o | output | 32 | Initial count, reads zero in modes 10/11 |
| cur_cnt_o | output | 32 | Current count, reads zero in modes 10/11 |
| div_cfg_o | output | 32 | Divide setting (bits 3, 1, 0) |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Consumer accepts the request |
| irq_vec | output | 8 | Vector of the pending request |

## Verification
The embedded properties watch, on every cycle, the relations that hold between count state and control. These are: the hold of the count between steps, the stop at zero in one-shot mode, the reload and the upper bound on the count in periodic mode, zero counts in the reserved modes, the forced mask while disabled, the link between a rising request and an open mask, and the stability of a request that is not yet accepted. The exact step spacing for each divisor code, the bit packing of the register reads, and the effect of writes that change mode or load zero can only be shown by scenarios. In those scenarios a behavioural model runs alongside the design, and its values are compared on every clock.

// File: rtl/loc_timer_pkg.sv
package loc_timer_pkg;
  localparam int CODE_W = 3;
  localparam int PRE_W  = (1 << CODE_W) - 1;
  localparam int DIVR_W = PRE_W + 1;
  localparam int MASK_POS = 16;
  localparam int MODE_POS = 17;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_INIT  = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_RSVD_A   = 2'b10,
    MODE_RSVD_B   = 2'b11
  } tmode_e;

  function automatic logic [DIVR_W-1:0] divisor_of(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] sh;
    sh = code + CODE_W'(1);
    return DIVR_W'(1) << sh;
  endfunction

  function automatic logic mode_counts(input logic [1:0] m);
    return ~m[1];
  endfunction
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import loc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [PRE_W-1:0]  cnt_q;
  logic [DIVR_W-1:0] lim;

  assign lim  = divisor_of(code) - DIVR_W'(1);
  assign tick = run && ({1'b0, cnt_q} >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart || !run || tick) cnt_q <= '0;
    else                              cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = tick && (cur_q == ONE) && !load && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (clear) begin
      init_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      init_q <= load_val;
      cur_q  <= load_val;
    end else if (tick) begin
      if (cur_q == ONE) cur_q <= periodic ? init_q : '0;
      else              cur_q <= cur_q - ONE;
    end
  end

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clear) |=> $stable(cur_q));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> (cur_q == '0));
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (cur_q == $past(init_q)));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= init_q);
endmodule

// File: rtl/lt_irq_port.sv
module lt_irq_port #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [VEC_W-1:0] fire_vec,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (!valid || ready) begin
      valid <= fire;
      if (fire) vec <= fire_vec;
    end
  end

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(vec)));
endmodule

// File: rtl/loc_timer.sv
module loc_timer
  import loc_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_enable,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      entry_o,
  output logic [CNT_W-1:0] init_cnt_o,
  output logic [CNT_W-1:0] cur_cnt_o,
  output logic [31:0]      div_cfg_o,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int GAP_W = MASK_POS - VEC_W;
  localparam int TOP_W = 32 - MODE_POS - 2;

  logic [VEC_W-1:0]  vec_q;
  logic              mask_q;
  logic [1:0]        mode_q;
  logic [CODE_W-1:0] code_q;

  logic wr_entry, wr_init, wr_div;
  logic [1:0] new_mode;
  logic mode_chg, load, tick, expire, fire, counting;
  logic [CNT_W-1:0] init_q, cur_q;

  assign wr_entry = wr_en && (wsel_e'(wr_sel) == SEL_ENTRY);
  assign wr_init  = wr_en && (wsel_e'(wr_sel) == SEL_INIT);
  assign wr_div   = wr_en && (wsel_e'(wr_sel) == SEL_DIV);
  assign new_mode = wr_data[MODE_POS +: 2];
  assign counting = mode_counts(mode_q);
  assign mode_chg = wr_entry && (new_mode != mode_q);
  assign load     = wr_init && counting;
  assign fire     = expire && !mask_q && sw_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      mode_q <= MODE_ONESHOT;
    end else if (wr_entry) begin
      vec_q  <= wr_data[VEC_W-1:0];
      mask_q <= wr_data[MASK_POS] | ~sw_enable;
      mode_q <= new_mode;
    end else if (!sw_enable) begin
      mask_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= '0;
    else if (wr_div) code_q <= {wr_data[3], wr_data[1], wr_data[0]};
  end

  lt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cur_q != '0),
    .restart (load || mode_chg),
    .code    (code_q),
    .tick    (tick)
  );

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (wr_data[CNT_W-1:0]),
    .clear    (mode_chg),
    .tick     (tick),
    .periodic (mode_q == MODE_PERIODIC),
    .init_q   (init_q),
    .cur_q    (cur_q),
    .expire   (expire)
  );

  lt_irq_port #(.VEC_W(VEC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .fire_vec (vec_q),
    .ready    (irq_ready),
    .valid    (irq_valid),
    .vec      (irq_vec)
  );

  assign entry_o    = {{TOP_W{1'b0}}, mode_q, mask_q, {GAP_W{1'b0}}, vec_q};
  assign div_cfg_o  = {28'd0, code_q[2], 1'b0, code_q[1:0]};
  assign init_cnt_o = counting ? init_q : '0;
  assign cur_cnt_o  = counting ? cur_q  : '0;

  // R10
  disable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |=> mask_q);
  // R8
  rsvd_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !counting |-> (init_q == '0 && cur_q == '0));
  // R11
  irq_needs_open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(!mask_q && sw_enable));
endmodule

// File: tb/tb_loc_timer.sv
module tb_loc_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic irq_ready = 1'b0;
  logic [31:0] entry_o, init_cnt_o, cur_cnt_o, div_cfg_o;
  logic irq_valid;
  logic [7:0] irq_vec;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  loc_timer dut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .entry_o(entry_o), .init_cnt_o(init_cnt_o), .cur_cnt_o(cur_cnt_o),
    .div_cfg_o(div_cfg_o), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vec(irq_vec)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_vecf, m_mode, m_code, m_init, m_cur, m_pre, m_vec;
  bit m_mask, m_pend;
  int dv;
  bit run, tick, w_ent, w_ini, w_div, chg, ld, expd, fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vecf = 0; m_mode = 0; m_mask = 1; m_code = 0;
      m_init = 0; m_cur = 0; m_pre = 0; m_pend = 0; m_vec = 0;
    end else begin
      dv    = 1 << ((m_code + 1) % 8);
      run   = (m_cur != 0);
      tick  = run && (m_pre >= dv - 1);
      w_ent = wr_en && wr_sel == 2'd0;
      w_ini = wr_en && wr_sel == 2'd1;
      w_div = wr_en && wr_sel == 2'd2;
      chg   = w_ent && (int'(wr_data[18:17]) != m_mode);
      ld    = w_ini && (m_mode < 2);
      expd  = tick && m_cur == 1 && !chg && !ld;
      fire  = expd && !m_mask && sw_enable;
      m_pre = (ld || chg || !run || tick) ? 0 : m_pre + 1;
      if (chg) begin m_init = 0; m_cur = 0; end
      else if (ld) begin m_init = int'(wr_data); m_cur = int'(wr_data); end
      else if (tick) m_cur = (m_cur == 1) ? ((m_mode == 1) ? m_init : 0) : m_cur - 1;
      if (!m_pend || irq_ready) begin
        m_pend = fire;
        if (fire) m_vec = m_vecf;
      end
      if (w_ent) begin
        m_vecf = int'(wr_data[7:0]);
        m_mask = wr_data[16] || !sw_enable;
        m_mode = int'(wr_data[18:17]);
      end else if (!sw_enable) m_mask = 1;
      if (w_div) m_code = int'({wr_data[3], wr_data[1], wr_data[0]});
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "entry", entry_o, {13'd0, 2'(m_mode), m_mask, 8'd0, 8'(m_vecf)});
      chk(cur_req, "init", init_cnt_o, (m_mode < 2) ? m_init : 0);
      chk(cur_req, "cur", cur_cnt_o, (m_mode < 2) ? m_cur : 0);
      chk(cur_req, "div", div_cfg_o, {28'd0, 1'(m_code >> 2), 1'b0, 2'(m_code)});
      chk(cur_req, "irq_valid", 32'(irq_valid), 32'(m_pend));
      chk(cur_req, "irq_vec", 32'(irq_vec), 32'(8'(m_vec)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", "entry", entry_o, 32'h0001_0000);
    chk("R1", "cur", cur_cnt_o, 0);
    chk("R1", "div", div_cfg_o, 0);
    chk("R1", "irq_valid", 32'(irq_valid), 0);

    // R2 divide register bits
    cur_req = "R2";
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R2", "div kept bits", div_cfg_o, 32'h0000_000B);

    // R11 / R5 one-shot expiry, divide by 1
    cur_req = "R5";
    wr(2'd0, 32'h0000_0041);
    wr(2'd1, 32'd5);
    idle(5);
    chk("R5", "cur at zero", cur_cnt_o, 0);
    chk("R11", "irq_valid", 32'(irq_valid), 1);
    chk("R11", "irq_vec", 32'(irq_vec), 32'h41);
    cur_req = "R12";
    idle(3);
    chk("R12", "held", 32'(irq_valid), 1);
    irq_ready = 1'b1;
    idle(1);
    irq_ready = 1'b0;
    chk("R12", "dropped", 32'(irq_valid), 0);
    chk("R5", "stays zero", cur_cnt_o, 0);

    // R3 divide by 4 (code 1)
    cur_req = "R3";
    wr(2'd2, 32'h0000_0001);
    wr(2'd1, 32'd10);
    idle(3);
    chk("R3", "before step", cur_cnt_o, 10);
    idle(1);
    chk("R3", "first step", cur_cnt_o, 9);
    idle(4);
    chk("R3", "second step", cur_cnt_o, 8);

    // R6 periodic, divide by 2
    cur_req = "R6";
    wr(2'd0, 32'h0002_0022);
    wr(2'd2, 32'h0000_0000);
    irq_ready = 1'b1;
    wr(2'd1, 32'd3);
    idle(20);
    chk("R6", "still running", 32'(cur_cnt_o != 0), 1);
    chk("R6", "init kept", init_cnt_o, 3);

    // R7 mode change clears counts
    cur_req = "R7";
    wr(2'd0, 32'h0000_0022);
    chk("R7", "init cleared", init_cnt_o, 0);
    chk("R7", "cur cleared", cur_cnt_o, 0);

    // R8 reserved mode
    cur_req = "R8";
    wr(2'd0, 32'h0004_0000);
    wr(2'd1, 32'd7);
    idle(2);
    chk("R8", "init ignored", init_cnt_o, 0);
    chk("R8", "cur zero", cur_cnt_o, 0);

    // R9 entry field layout
    cur_req = "R9";
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R9", "entry bits", entry_o, 32'h0007_00FF);

    // R10 software disable, R11 masked expiry
    cur_req = "R10";
    wr(2'd0, 32'h0000_0030);
    chk("R10", "unmasked while enabled", entry_o, 32'h0000_0030);
    sw_enable = 1'b0;
    idle(1);
    chk("R10", "mask forced", entry_o, 32'h0001_0030);
    wr(2'd0, 32'h0000_0031);
    chk("R10", "write masked", entry_o, 32'h0001_0031);
    cur_req = "R11";
    irq_ready = 1'b0;
    wr(2'd2, 32'h0000_000B);
    wr(2'd1, 32'd2);
    idle(4);
    chk("R11", "masked no irq", 32'(irq_valid), 0);
    sw_enable = 1'b1;

    // R4 zero write stops
    cur_req = "R4";
    wr(2'd0, 32'h0000_0031);
    wr(2'd1, 32'd100);
    chk("R4", "loaded", init_cnt_o, 100);
    idle(3);
    wr(2'd1, 32'd0);
    chk("R4", "cur stopped", cur_cnt_o, 0);
    chk("R4", "init zero", init_cnt_o, 0);
    idle(5);
    chk("R4", "still stopped", cur_cnt_o, 0);

    // R12 back-to-back expiry while accepting
    cur_req = "R12";
    irq_ready = 1'b1;
    wr(2'd0, 32'h0002_0055);
    wr(2'd1, 32'd1);
    idle(6);
    chk("R12", "continuous valid", 32'(irq_valid), 1);
    chk("R12", "vector", 32'(irq_vec), 32'h55);

    // R2 divide by 128 (code 6)
    cur_req = "R2";
    wr(2'd0, 32'h0000_0066);
    wr(2'd2, 32'h0000_000A);
    wr(2'd1, 32'd2);
    idle(127);
    chk("R2", "no step before 128", cur_cnt_o, 2);
    idle(1);
    chk("R2", "step at 128", cur_cnt_o, 1);
    idle(140);
    chk("R2", "expired", cur_cnt_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule